// File: doc/BRIEF.md
# Byte-Serial AES Round Front-End

This block performs the byte-level front half of one AES round on a 128-bit state, one byte per step. In the forward direction it adds the round key, substitutes each byte through the AES S-box, and applies the row rotation in a single 16-step loop. In the reverse direction the same loop applies the inverse row rotation, the inverse S-box and then the round key. The row rotation is not wired. The read index steps by one each byte, and the write index steps by a fixed stride modulo 16. Each byte therefore lands directly in its rotated position in the result register.

Substitution is computed, not looked up. A serial engine raises the byte to the 254th power in GF(2^8), one field multiply per cycle, and applies the affine map as a ring product modulo x^8+1. Only one byte is in the engine at a time. The pointers advance only when the engine reports completion, so every operation takes the same number of cycles whatever the data or direction. Column mixing, key expansion and round sequencing belong to the surrounding logic.

Top module: `aes_round_front`

## Requirements
- R1: Byte i of any 128-bit bus is bits [127-8i -: 8], with bytes in column-major order (byte index = 4*column + row).
- R2: With `decrypt`=0, `result` = ShiftRows(SubBytes(`state_in` XOR `key_in`)). Source byte i is written to result byte (13*i) mod 16.
- R3: With `decrypt`=1, `result` = InvSubBytes(InvShiftRows(`state_in`)) XOR `key_in`. Source byte i goes to result byte (5*i) mod 16, and the key byte used is the one at that destination index.
- R4: `done` rises exactly 256 clock edges after the edge that samples `start` (16 bytes of 16 cycles each). This holds for both directions and all data, and the S-box engine never holds more than one byte.
- R5: `done` is high for exactly one cycle. `busy` is low in that cycle, and `result` already holds the full answer.
- R6: A `start` that is high while `busy` is high is ignored. The running operation finishes with its own result, and no extra operation follows.
- R7: `result` keeps its value while idle, until the write phase of the next accepted operation.
- R8: `state_in`, `key_in` and `decrypt` are captured on the accepting edge. Later changes during the operation have no effect.
- R9: The substitution maps 0x00 to 0x63 in the forward direction, and 0x63 to 0x00 in the reverse direction.
- R10: After reset, `result` is all zero and both `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| decrypt | input | 1 | 0 = forward pass, 1 = inverse pass |
| state_in | input | 128 | Input state, byte 0 in bits [127:120] |
| key_in | input | 128 | Round key, same byte order |
| result | output | 128 | Output state register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses published round-1 and round-2 intermediate values in both directions, with zero and non-zero keys. A wrong stride would scramble rows 1 to 3 while row 0 stayed correct, and a reversed byte order would corrupt every byte. Inverse runs with a non-zero key check that the key is added at the destination index. Adding it at the source index would leave a permuted key in the result. The bench also checks the zero-byte substitution, and the fixed 256-cycle latency in both directions, which catches a data-dependent or mis-counted engine. It raises `start` during a running operation and changes the operands mid-flight. A design that re-armed on the second start, or read the live input bus, would return the wrong state or pulse `done` twice.

// File: rtl/aesfe_pkg.sv
package aesfe_pkg;
   localparam int BYTE_W   = 8;
   localparam logic [BYTE_W-1:0] FIELD_RED = 8'h1B;   // x^8 = x^4+x^3+x+1
   localparam logic [BYTE_W-1:0] FWD_MASK  = 8'h1F;   // rotations 0..4
   localparam logic [BYTE_W-1:0] FWD_CONST = 8'h63;
   localparam logic [BYTE_W-1:0] INV_MASK  = 8'h4A;   // rotations 1,3,6
   localparam logic [BYTE_W-1:0] INV_CONST = 8'h05;

   // product in GF(2^8) by shift-and-add with reduction
   function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] b);
      logic [BYTE_W-1:0] acc;
      logic [BYTE_W-1:0] sh;
      acc = '0;
      sh  = a;
      for (int j = 0; j < BYTE_W; j++) begin
         if (b[j]) acc = acc ^ sh;
         sh = sh[BYTE_W-1] ? ({sh[BYTE_W-2:0], 1'b0} ^ FIELD_RED)
                           : {sh[BYTE_W-2:0], 1'b0};
      end
      return acc;
   endfunction

   // product in the ring modulo x^8+1: XOR of rotations chosen by mask
   function automatic logic [BYTE_W-1:0] ring_mul(input logic [BYTE_W-1:0] b,
                                                  input logic [BYTE_W-1:0] m);
      logic [BYTE_W-1:0] acc;
      logic [BYTE_W-1:0] rot;
      acc = '0;
      rot = b;
      for (int j = 0; j < BYTE_W; j++) begin
         if (m[j]) acc = acc ^ rot;
         rot = {rot[BYTE_W-2:0], rot[BYTE_W-1]};
      end
      return acc;
   endfunction
endpackage

// File: rtl/aesfe_sbox_engine.sv
module aesfe_sbox_engine
   import aesfe_pkg::*;
#(
   parameter int  BW               = BYTE_W,
   parameter bit  DEDICATED_SQUARE = 1'b0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          inv,
   input  logic [BW-1:0] din,
   output logic [BW-1:0] dout,
   output logic          done,
   output logic          busy
);
   localparam int STEPS = 2 * (BW - 1);           // x^254 by square-and-multiply
   localparam int CW    = $clog2(STEPS + 1);

   generate
      if (BW != 8) begin : g_bad_width
         $error("aesfe_sbox_engine: byte width must be 8");
      end
   endgenerate

   logic [BW-1:0] base_q, acc_q, step_val, pre_val;
   logic [CW-1:0] cnt_q;
   logic          run_q, inv_q;

   assign pre_val = inv ? (ring_mul(din, INV_MASK) ^ INV_CONST) : din;

   generate
      if (DEDICATED_SQUARE) begin : g_split
         logic [BW-1:0] sq_val, mx_val;
         assign sq_val   = gf_mul(acc_q, acc_q);
         assign mx_val   = gf_mul(acc_q, base_q);
         assign step_val = cnt_q[0] ? sq_val : mx_val;
      end else begin : g_shared
         assign step_val = gf_mul(acc_q, cnt_q[0] ? acc_q : base_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         acc_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         inv_q  <= 1'b0;
         dout   <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && !run_q) begin
            base_q <= pre_val;
            acc_q  <= {{(BW-1){1'b0}}, 1'b1};
            cnt_q  <= '0;
            run_q  <= 1'b1;
            inv_q  <= inv;
         end else if (run_q) begin
            acc_q <= step_val;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(STEPS - 1)) begin
               run_q <= 1'b0;
               done  <= 1'b1;
               dout  <= inv_q ? step_val
                              : (ring_mul(step_val, FWD_MASK) ^ FWD_CONST);
            end
         end
      end
   end

   assign busy = run_q;
endmodule

// File: rtl/aesfe_ptr_seq.sv
module aesfe_ptr_seq #(
   parameter int NB = 16
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   adv,
   input  logic                   inv,
   output logic [$clog2(NB)-1:0]  rd_idx,
   output logic [$clog2(NB)-1:0]  wr_idx,
   output logic                   last
);
   localparam int IW       = $clog2(NB);
   localparam int ROWS     = 4;
   localparam int COLS     = NB / ROWS;
   localparam int FWD_STEP = NB - COLS + 1;   // 13 for a 4x4 state
   localparam int INV_STEP = COLS + 1;        // 5 for a 4x4 state

   generate
      if ((NB & (NB - 1)) != 0 || NB != ROWS * ROWS) begin : g_bad_nb
         $error("aesfe_ptr_seq: state must be 4x4 bytes");
      end
   endgenerate

   logic [IW-1:0] stride;
   assign stride = inv ? IW'(INV_STEP) : IW'(FWD_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_idx <= '0;
         wr_idx <= '0;
      end else if (clr) begin
         rd_idx <= '0;
         wr_idx <= '0;
      end else if (adv) begin
         rd_idx <= rd_idx + 1'b1;
         wr_idx <= wr_idx + stride;     // wraps modulo NB
      end
   end

   assign last = (rd_idx == IW'(NB - 1));
endmodule

// File: rtl/aesfe_ctrl.sv
module aesfe_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sb_done,
   input  logic sb_busy,
   input  logic last,
   output logic accept,
   output logic sb_go,
   output logic wr_en,
   output logic busy,
   output logic done
);
   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} ctrl_e;
   ctrl_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      accept  = 1'b0;
      sb_go   = 1'b0;
      wr_en   = 1'b0;
      unique case (state_q)
         S_IDLE: if (start) begin
            accept  = 1'b1;
            state_d = S_ISSUE;
         end
         S_ISSUE: if (!sb_busy) begin
            sb_go   = 1'b1;
            state_d = S_WAIT;
         end
         S_WAIT: if (sb_done) begin
            wr_en   = 1'b1;
            state_d = last ? S_IDLE : S_ISSUE;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= wr_en && last;
      end
   end

   assign busy = (state_q != S_IDLE);
endmodule

// File: rtl/aes_round_front.sv
module aes_round_front
   import aesfe_pkg::*;
#(
   parameter int NB          = 16,
   parameter int BW          = BYTE_W,
   parameter bit FAST_SQUARE = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              decrypt,
   input  logic [NB*BW-1:0]  state_in,
   input  logic [NB*BW-1:0]  key_in,
   output logic [NB*BW-1:0]  result,
   output logic              busy,
   output logic              done
);
   localparam int SW = NB * BW;
   localparam int IW = $clog2(NB);

   generate
      if (NB != 16 || BW != 8) begin : g_bad_cfg
         $error("aes_round_front: requires 16 bytes of 8 bits");
      end
   endgenerate

   logic [SW-1:0] st_q, key_q;
   logic          inv_q;
   logic [BW-1:0] st_b  [NB];
   logic [BW-1:0] key_b [NB];
   logic [BW-1:0] res_b [NB];

   logic          accept, sb_go, sb_done, sb_busy, wr_en, last;
   logic [IW-1:0] rd_idx, wr_idx;
   logic [BW-1:0] sb_in, sb_out, wr_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         key_q <= '0;
         inv_q <= 1'b0;
      end else if (accept) begin
         st_q  <= state_in;
         key_q <= key_in;
         inv_q <= decrypt;
      end
   end

   generate
      for (genvar i = 0; i < NB; i++) begin : g_byte
         assign st_b[i]  = st_q [SW-1-i*BW -: BW];
         assign key_b[i] = key_q[SW-1-i*BW -: BW];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             res_b[i] <= '0;
            else if (wr_en && wr_idx == IW'(i))     res_b[i] <= wr_byte;
         end
         assign result[SW-1-i*BW -: BW] = res_b[i];
      end
   endgenerate

   // forward: key added before substitution at the source index
   assign sb_in   = inv_q ? st_b[rd_idx] : (st_b[rd_idx] ^ key_b[rd_idx]);
   // inverse: key added after substitution at the destination index
   assign wr_byte = inv_q ? (sb_out ^ key_b[wr_idx]) : sb_out;

   aesfe_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .sb_done (sb_done),
      .sb_busy (sb_busy),
      .last    (last),
      .accept  (accept),
      .sb_go   (sb_go),
      .wr_en   (wr_en),
      .busy    (busy),
      .done    (done)
   );

   aesfe_ptr_seq #(.NB(NB)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .adv    (wr_en),
      .inv    (inv_q),
      .rd_idx (rd_idx),
      .wr_idx (wr_idx),
      .last   (last)
   );

   aesfe_sbox_engine #(.BW(BW), .DEDICATED_SQUARE(FAST_SQUARE)) u_sbox (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (sb_go),
      .inv   (inv_q),
      .din   (sb_in),
      .dout  (sb_out),
      .done  (sb_done),
      .busy  (sb_busy)
   );
endmodule

// File: rtl/aesfe_checker.sv
module aesfe_checker #(
   parameter int NB  = 16,
   parameter int BW  = 8,
   parameter int LAT = NB * (2 * (BW - 1) + 2)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [NB*BW-1:0]  result,
   input logic              sb_go,
   input logic              sb_busy
);
   logic [15:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat_cnt <= '0;
      else if (start && !busy)   lat_cnt <= '0;
      else if (busy)             lat_cnt <= lat_cnt + 1'b1;
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                 // R5
   AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);                                           // R5
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(result));                                      // R7
   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == 16'(LAT)));                                 // R4
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      sb_go |-> !sb_busy);                                             // R4
endmodule

bind aes_round_front aesfe_checker #(.NB(16), .BW(8)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .result  (result),
   .sb_go   (sb_go),
   .sb_busy (sb_busy)
);

// File: tb/tb_aes_round_front.sv
module tb_aes_round_front;
   localparam int  NB  = 16;
   localparam int  BW  = 8;
   localparam int  LAT = NB * (1 + 2 * (BW - 1) + 1);  // issue, 14 multiplies, write

   localparam logic [127:0] PT     = 128'h3243f6a8885a308d313198a2e0370734;
   localparam logic [127:0] K0     = 128'h2b7e151628aed2a6abf7158809cf4f3c;
   localparam logic [127:0] R1_IN  = 128'h193de3bea0f4e22b9ac68d2ae9f84808;
   localparam logic [127:0] R1_OUT = 128'hd4bf5d30e0b452aeb84111f11e2798e5;
   localparam logic [127:0] R2_IN  = 128'ha49c7ff2689f352b6b5bea43026a5049;
   localparam logic [127:0] R2_OUT = 128'h49db873b453953897f02d2f177de961a;
   localparam logic [127:0] ALL63  = {16{8'h63}};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         decrypt = 1'b0;
   logic [127:0] state_in = '0;
   logic [127:0] key_in = '0;
   logic [127:0] result;
   logic         busy, done;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   aes_round_front dut (
      .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
      .state_in(state_in), .key_in(key_in),
      .result(result), .busy(busy), .done(done)
   );

   task automatic chk_vec(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [127:0] s, input logic [127:0] k, input logic d,
                         output logic [127:0] r, output int lat);
      @(negedge clk);
      state_in = s; key_in = k; decrypt = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 2000) begin
         @(negedge clk);
         lat++;
      end
      r = result;
   endtask

   task automatic t_reset;
      chk_vec("R10 result after reset", result, '0);
      chk_int("R10 busy after reset", int'(busy), 0);
      chk_int("R10 done after reset", int'(done), 0);
   endtask

   task automatic t_case(input string req, input logic [127:0] s, input logic [127:0] k,
                         input logic d, input logic [127:0] exp);
      logic [127:0] r;
      int lat;
      run_op(s, k, d, r, lat);
      chk_vec(req, r, exp);
      chk_int({req, " R4 latency"}, lat, LAT);
      chk_int({req, " R5 busy low with done"}, int'(busy), 0);
      @(negedge clk);
      chk_int({req, " R5 done width"}, int'(done), 0);
   endtask

   task automatic t_forward;
      t_case("R2 R1 round1 key0", R1_IN, '0, 1'b0, R1_OUT);
      t_case("R2 round1 from plaintext and key", PT, K0, 1'b0, R1_OUT);
      t_case("R2 round2 key0", R2_IN, '0, 1'b0, R2_OUT);
   endtask

   task automatic t_inverse;
      t_case("R3 round1 key0", R1_OUT, '0, 1'b1, R1_IN);
      t_case("R3 round1 with key", R1_OUT, K0, 1'b1, PT);
      t_case("R3 round2 key0", R2_OUT, '0, 1'b1, R2_IN);
      t_case("R3 key at destination", ALL63, K0, 1'b1, K0);
   endtask

   task automatic t_zero;
      t_case("R9 zero forward", '0, '0, 1'b0, ALL63);
      t_case("R9 0x63 inverse", ALL63, '0, 1'b1, '0);
   endtask

   task automatic t_busy_start;
      int extra;
      @(negedge clk);
      state_in = PT; key_in = K0; decrypt = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      state_in = '0; key_in = '0; decrypt = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk_vec("R6 result of first op", result, R1_OUT);
      extra = 0;
      repeat (300) begin
         @(negedge clk);
         if (done || busy) extra++;
      end
      chk_int("R6 no second operation", extra, 0);
      chk_vec("R7 result held while idle", result, R1_OUT);
   endtask

   task automatic t_operand_change;
      @(negedge clk);
      state_in = R1_IN; key_in = '0; decrypt = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      state_in = '0; key_in = '1; decrypt = 1'b1;
      while (!done) @(negedge clk);
      chk_vec("R8 operands captured at start", result, R1_OUT);
   endtask

   initial begin
      #(20ns * 150000);
      n_fail++;
      $display("FAIL watchdog all-R actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_forward();
      t_inverse();
      t_zero();
      t_busy_start();
      t_operand_change();
      repeat (5) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule